// File: doc/BRIEF.md
# Signed Fixed-Point to Single-Precision Float Converter

This block turns a signed two's-complement fixed-point number into the 32-bit single-precision floating-point bit pattern. By default the input is 24 bits wide with 8 bits below the binary point, so it covers magnitudes from 2^-8 up to 32768. Because the input has fractional bits, the result can carry a negative true exponent: values smaller than one are encoded as well as whole numbers.

The conversion has four steps. The block takes the absolute value, finds the highest set bit, shifts the magnitude so that this bit lands in the hidden-bit position, and derives the biased exponent from the bit's position. Any magnitude bits that fall below the stored fraction field are cut off and never rounded. The packed word is held in a register that has a synchronous active-high reset. A pattern presented at one rising clock edge appears at the output after that edge.

Top module: `fx2fp_conv`

## Requirements
- R1: The output word has the sign in bit 31, the biased exponent in bits 30:23 and the stored fraction in bits 22:0. The leading significand bit is hidden. A value sampled at a rising edge is visible on `fp_out` right after that edge.
- R2: The exponent field equals the true power of two plus 127. The true power is the index of the highest set magnitude bit minus the number of fractional input bits (8), so an input of 14.25 (raw 0x000E40) gives exponent field 130.
- R3: A zero input yields 0x00000000, which is positive zero.
- R4: An input of 0.5 (raw 0x000080) yields 0x3F000000, and -0.5 (raw 0xFFFF80) yields 0xBF000000.
- R5: A negative input sets bit 31 and encodes its absolute value in bits 30:0. 14.25 gives 0x41640000 and -14.25 (raw 0xFFF1C0) gives 0xC1640000.
- R6: The most negative input (raw 0x800000, value -32768) yields 0xC7000000.
- R7: Magnitudes below one convert with a negative true exponent. The smallest positive input (raw 0x000001, 2^-8) yields 0x3B800000.
- R8: The fraction field holds the magnitude bits below the leading one, left-aligned and zero-filled on the right. Bits that fall below the field are dropped without rounding. The largest positive input (raw 0x7FFFFF) yields 0x46FFFFFE.
- R9: While `rst` is high at a rising edge, `fp_out` becomes 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| fix_in | input | 24 | Signed fixed-point input, 8 fractional bits |
| fp_out | output | 32 | Registered single-precision pattern |

## Verification
There is exactly one register between `fix_in` and `fp_out`, so each result is due one rising edge after the input is presented. The bench changes the input on a falling edge and waits through the next rising edge. It then compares the output on the falling edge that follows, which is half a period away from any update. This timing applies both to the directed corner cases (zero, ±0.5, ±14.25, the smallest and largest positive inputs, and the most negative input) and to a seeded random sweep. Each result is compared against a bench-side reference function.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SP_BIAS  = 127;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

  typedef struct packed {
    logic                sign;
    logic [SP_EXP_W-1:0] expo;
    logic [SP_MAN_W-1:0] frac;
  } sp_word_t;
endpackage

// File: rtl/fx2fp_mag.sv
module fx2fp_mag #(
  parameter int W = 24
) (
  input  logic [W-1:0] val,
  output logic         neg,
  output logic [W-1:0] mag
);
  assign neg = val[W-1];
  assign mag = neg ? (~val + W'(1)) : val;

  // Only the most negative input can leave the top magnitude bit set (R6)
  always_comb begin
    if (mag[W-1])
      assert_mag_top_R6: assert (val == {1'b1, {(W-1){1'b0}}});
  end
endmodule

// File: rtl/fx2fp_lead.sv
module fx2fp_lead #(
  parameter int W  = 24,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  mag,
  output logic [PW-1:0] pos,
  output logic          nz
);
  logic [W-1:0] onehot;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_hit
      if (i == W-1) begin : g_top
        assign onehot[i] = mag[i];
      end else begin : g_low
        assign onehot[i] = mag[i] & ~(|mag[W-1:i+1]);
      end
    end
  endgenerate

  assign nz = |mag;

  always_comb begin
    pos = '0;
    for (int k = 0; k < W; k++)
      if (onehot[k]) pos = pos | PW'(k);
  end

  // Encoded position must point at the highest set bit (R2)
  always_comb begin
    if (nz)
      assert_lead_pos_R2: assert ((mag >> pos) == W'(1));
  end
endmodule

// File: rtl/fx2fp_pack.sv
module fx2fp_pack
  import fx2fp_pkg::*;
#(
  parameter int W      = 24,
  parameter int FRAC_W = 8,
  parameter int PW     = $clog2(W)
) (
  input  logic [W-1:0]        mag,
  input  logic [PW-1:0]       pos,
  input  logic                nz,
  output logic [SP_EXP_W-1:0] expo,
  output logic [SP_MAN_W-1:0] frac
);
  localparam int OFS = SP_BIAS - FRAC_W;

  logic [W-1:0] norm;

  assign norm = mag << (PW'(W-1) - pos);
  assign expo = nz ? SP_EXP_W'(int'(pos) + OFS) : '0;

  generate
    if (W-1 >= SP_MAN_W) begin : g_trunc
      assign frac = norm[W-2 -: SP_MAN_W];
    end else begin : g_pad
      assign frac = {norm[W-2:0], {(SP_MAN_W-(W-1)){1'b0}}};
    end
  endgenerate

  // Normalized magnitude must carry the leading one in the hidden-bit slot (R8)
  always_comb begin
    if (nz)
      assert_norm_lead_R8: assert (norm[W-1]);
  end
endmodule

// File: rtl/fx2fp_conv.sv
module fx2fp_conv
  import fx2fp_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] fix_in,
  output logic [SP_W-1:0] fp_out
);
  localparam int PW = $clog2(IN_W);

  logic                neg;
  logic                nz;
  logic [IN_W-1:0]     mag;
  logic [PW-1:0]       pos;
  logic [SP_EXP_W-1:0] expo;
  logic [SP_MAN_W-1:0] frac;
  sp_word_t            nxt;

  fx2fp_mag #(.W(IN_W)) u_mag (
    .val(fix_in), .neg(neg), .mag(mag)
  );

  fx2fp_lead #(.W(IN_W), .PW(PW)) u_lead (
    .mag(mag), .pos(pos), .nz(nz)
  );

  fx2fp_pack #(.W(IN_W), .FRAC_W(FRAC_W), .PW(PW)) u_pack (
    .mag(mag), .pos(pos), .nz(nz), .expo(expo), .frac(frac)
  );

  always_comb begin
    nxt.sign = neg & nz;
    nxt.expo = expo;
    nxt.frac = frac;
  end

  always_ff @(posedge clk) begin
    if (rst) fp_out <= '0;
    else     fp_out <= nxt;
  end

  assert_reset_R9: assert property (@(posedge clk) rst |=> fp_out == '0);

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (fix_in == '0) |=> fp_out == '0);

  assert_sign_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fp_out[SP_W-1] == $past(fix_in[IN_W-1]));

  assert_exp_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    (fix_in != '0) |=> fp_out[SP_W-2 -: SP_EXP_W] != '0);
endmodule

// File: tb/sim_fx2fp_conv.sv
module sim_fx2fp_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] fix_in = '0;
  logic [31:0] fp_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  fx2fp_conv u0 (.clk(clk), .rst(rst), .fix_in(fix_in), .fp_out(fp_out));

  always #10 clk = ~clk;

  function automatic logic [31:0] ref_conv(input logic [23:0] x);
    logic [23:0] m;
    logic [23:0] sh;
    int p;
    m = x[23] ? (24'd0 - x) : x;
    if (m == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 24; i++) if (m[i]) p = i;
    sh = m << (23 - p);
    return {x[23], 8'(p - 8 + 127), sh[22:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [23:0] v, input logic [31:0] exp);
    @(negedge clk);
    fix_in = v;
    @(posedge clk);
    @(negedge clk);
    check(req, fp_out, exp);
  endtask

  initial begin
    int seed;
    logic [23:0] v;
    seed = $urandom(32'd4711);
    fix_in = 24'h000E40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", fp_out, 32'h0);
    rst = 1'b0;
    apply("R3", 24'h000000, 32'h00000000);
    apply("R4", 24'h000080, 32'h3F000000);
    apply("R4", 24'hFFFF80, 32'hBF000000);
    apply("R5", 24'h000E40, 32'h41640000);
    apply("R5", 24'hFFF1C0, 32'hC1640000);
    apply("R2", 24'h000E40, {1'b0, 8'd130, 23'h640000});
    apply("R6", 24'h800000, 32'hC7000000);
    apply("R7", 24'h000001, 32'h3B800000);
    apply("R8", 24'h7FFFFF, 32'h46FFFFFE);
    apply("R1", 24'h000100, 32'h3F800000);
    apply("R7", 24'hFFFFFF, 32'hBB800000);
    for (int n = 0; n < 400; n++) begin
      v = 24'($urandom);
      if (n % 4 == 1) v = v >> ($urandom % 24);
      apply("R1", v, ref_conv(v));
    end
    @(negedge clk);
    fix_in = 24'h000E40;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", fp_out, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule